// File: doc/BRIEF.md
# Dual-Mode Ramp and Successive-Approximation Conversion Controller

This block is the digital half of a comparator-based analog-to-digital converter. It drives the code input of an external D/A converter and reads back a single comparator bit. The unknown voltage feeds the comparator's non-inverting input and the D/A output feeds its inverting input. A comparator value of 1 therefore means the unknown voltage is still above the trial level.

A conversion begins on a start pulse, and the mode input sampled at that moment picks the algorithm. Ramp mode is a linear search: it walks the code upward from zero until the comparator drops. Successive-approximation mode is a binary search: it resolves one bit per trial, from the most significant bit down.

The comparator bit crosses into the clock domain through a synchronizer. Every trial code is held for a fixed number of settle cycles, plus the synchronizer depth, before its comparator value is used. When the conversion ends, a one-cycle completion pulse is raised and the result is held until the next conversion completes.

Top module: `ramp_sar_conv`

## Requirements
- R1: After reset, code_o, result_o, over_o and done_o are all zero.
- R2: In ramp mode (mode_i = 0 at start) the first trial code is 0, and each later trial code is exactly one above the previous one.
- R3: In ramp mode the conversion ends at the first trial code whose comparator value is 0. That code becomes result_o and over_o is 0.
- R4: In ramp mode, if the all-ones code still reads a comparator value of 1, the conversion ends with result_o all ones and over_o set to 1.
- R5: In successive-approximation mode (mode_i = 1 at start) the first trial code has only the most significant bit set (0x8000 at the default width of 16).
- R6: In successive-approximation mode a comparator value of 1 keeps the bit under test and 0 clears it. The next lower bit is then set as the new trial. A result needs exactly WIDTH tests, and over_o is 0.
- R7: Each trial code is held for SETTLE_CYCLES + SYNC_STAGES + 1 clock cycles, and its comparator value is used at the end of that hold. A conversion of n trials raises done_o n × (SETTLE_CYCLES + SYNC_STAGES + 1) cycles after the edge that accepted start.
- R8: done_o is high for exactly one cycle per conversion. result_o and over_o change only in that cycle and stay stable otherwise, including across a new start.
- R9: A start, with any mode value, that arrives while a conversion is running is ignored. The running conversion keeps its mode, result and timing, and no extra done_o pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion when idle |
| mode_i | input | 1 | Algorithm select sampled at start: 0 ramp, 1 successive approximation |
| code_o | output | WIDTH | Trial code to the external D/A converter |
| cmp_i | input | 1 | Comparator output, asynchronous; 1 means input above D/A level |
| result_o | output | WIDTH | Converted value of the last finished conversion |
| over_o | output | 1 | Ramp reached all ones without a comparator drop |
| done_o | output | 1 | One-cycle pulse when a conversion finishes |

## Verification
The checks inside the design assume the unknown voltage is constant for the whole conversion. They also assume the comparator reflects the trial code within the synchronizer depth, so that every sampled bit belongs to the current trial. The bench models the comparator as a combinational compare of a stored level against code_o, which it changes only between conversions. It uses a reduced code width so that full-scale and overrange ramps fit the run. Start pulses arrive only while idle, except for one deliberate stray pulse that tests R9.

// File: rtl/conv_pkg.sv
package conv_pkg;

    typedef enum logic {
        MODE_RAMP = 1'b0,
        MODE_SAR  = 1'b1
    } conv_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_TRIAL = 1'b1
    } conv_state_e;

endpackage

// File: rtl/conv_sync.sv
module conv_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/conv_settle_timer.sv
module conv_settle_timer #(
    parameter int unsigned HOLD = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = CW'(HOLD);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R7: the hold counter never leaves its programmed window
    p_timer_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(HOLD));
endmodule

// File: rtl/conv_code_step.sv
module conv_code_step
    import conv_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  conv_mode_e       mode_i,
    input  logic [WIDTH-1:0] code_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] nxt_code_o,
    output logic [WIDTH-1:0] nxt_mask_o,
    output logic             finish_o,
    output logic [WIDTH-1:0] res_o,
    output logic             over_o
);
    localparam logic [WIDTH-1:0] ALL1 = '1;

    logic [WIDTH-1:0] kept;
    assign kept = cmp_i ? code_i : (code_i & ~mask_i);

    always_comb begin
        nxt_code_o = code_i;
        nxt_mask_o = mask_i;
        finish_o   = 1'b0;
        res_o      = code_i;
        over_o     = 1'b0;
        if (mode_i == MODE_RAMP) begin
            if (!cmp_i) begin
                finish_o = 1'b1;
            end else if (code_i == ALL1) begin
                finish_o = 1'b1;
                over_o   = 1'b1;
            end else begin
                nxt_code_o = code_i + 1'b1;
            end
        end else begin
            res_o = kept;
            if (mask_i[0]) begin
                finish_o = 1'b1;
            end else begin
                nxt_mask_o = mask_i >> 1;
                nxt_code_o = kept | (mask_i >> 1);
            end
        end
    end
endmodule

// File: rtl/ramp_sar_conv.sv
module ramp_sar_conv
    import conv_pkg::*;
#(
    parameter int unsigned WIDTH         = 16,
    parameter int unsigned SETTLE_CYCLES = 2,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             mode_i,
    output logic [WIDTH-1:0] code_o,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] result_o,
    output logic             over_o,
    output logic             done_o
);
    localparam int unsigned HOLD = SETTLE_CYCLES + SYNC_STAGES;
    localparam int unsigned TW   = WIDTH + 1;
    localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        conv_state_e      state;
        conv_mode_e       mode;
        logic [WIDTH-1:0] code;
        logic [WIDTH-1:0] mask;
        logic [WIDTH-1:0] result;
        logic             over;
        logic             done;
        logic [TW-1:0]    tests;
    } regs_t;

    regs_t s_d, s_q;
    logic  cmp_sync, tmr_load, tmr_expired;
    logic  st_finish, st_over;
    logic [WIDTH-1:0] st_code, st_mask, st_res;

    conv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (cmp_i),
        .sync_o  (cmp_sync)
    );

    conv_settle_timer #(.HOLD(HOLD)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    conv_code_step #(.WIDTH(WIDTH)) u_step (
        .mode_i     (s_q.mode),
        .code_i     (s_q.code),
        .mask_i     (s_q.mask),
        .cmp_i      (cmp_sync),
        .nxt_code_o (st_code),
        .nxt_mask_o (st_mask),
        .finish_o   (st_finish),
        .res_o      (st_res),
        .over_o     (st_over)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.mode  = conv_mode_e'(mode_i);
                    s_d.code  = (conv_mode_e'(mode_i) == MODE_SAR) ? MSB : '0;
                    s_d.mask  = MSB;
                    s_d.tests = '0;
                    s_d.state = ST_TRIAL;
                    tmr_load  = 1'b1;
                end
            end
            ST_TRIAL: begin
                if (tmr_expired) begin
                    s_d.tests = s_q.tests + 1'b1;
                    if (st_finish) begin
                        s_d.result = st_res;
                        s_d.over   = st_over;
                        s_d.done   = 1'b1;
                        s_d.state  = ST_IDLE;
                    end else begin
                        s_d.code = st_code;
                        s_d.mask = st_mask;
                        tmr_load = 1'b1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign code_o   = s_q.code;
    assign result_o = s_q.result;
    assign over_o   = s_q.over;
    assign done_o   = s_q.done;

    // R2: ramp trial codes only hold or climb by one
    p_ramp_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_TRIAL && $past(s_q.state) == ST_TRIAL && s_q.mode == MODE_RAMP)
        |-> (code_o == $past(code_o) || code_o == WIDTH'($past(code_o) + 1'b1)));

    // R4: the overrange flag only accompanies an all-ones result
    p_over_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        over_o |-> (result_o == '1));

    // R5: an accepted binary-search start presents the top bit alone
    p_sar_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_IDLE && start_i && mode_i == 1'b1) |=> (code_o == MSB));

    // R6: exactly one bit is under test, and a binary search ends after WIDTH tests
    p_mask_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(s_q.mask));
    p_sar_tests_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && s_q.mode == MODE_SAR) |-> (s_q.tests == TW'(WIDTH)));

    // R8: completion is a single-cycle pulse, and results move only with it
    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(result_o) && $stable(over_o)));

    // R9: a start during a conversion does not disturb its mode
    p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_TRIAL && start_i) |=> (s_q.mode == $past(s_q.mode)));
endmodule

// File: tb/sim_ramp_sar_conv.sv
module sim_ramp_sar_conv;
    localparam int W    = 10;
    localparam int SET  = 2;
    localparam int SYN  = 2;
    localparam int STEP = SET + SYN + 1;
    localparam int MAXV = (1 << W) - 1;

    typedef struct {
        logic [W-1:0] res;
        logic         over;
        logic         sar;
        int           lat;
        int           t0;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic         cmp;
    logic [W-1:0] code, result;
    logic         over, done;
    logic [W:0]   vin = '0;

    int checks = 0, failures = 0, cyc = 0, issued = 0, ndone = 0;
    logic [W-1:0] last_res = '0;
    logic done_prev = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign cmp = (vin > {1'b0, code});

    ramp_sar_conv #(.WIDTH(W), .SETTLE_CYCLES(SET), .SYNC_STAGES(SYN)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .code_o(code), .cmp_i(cmp), .result_o(result), .over_o(over), .done_o(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected items when the design signals completion
    initial begin
        forever begin
            @(negedge clk);
            if (done_prev) check("R8 done pulse width", int'(done), 0);
            done_prev = done;
            if (done) begin
                if (q.size() == 0) begin
                    check("R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.sar ? "R6 sar result" : "R3 ramp result", int'(result), int'(e.res));
                    check(e.sar ? "R6 sar over flag" : "R4 ramp over flag", int'(over), int'(e.over));
                    check("R7 conversion latency", cyc - e.t0, e.lat);
                end
                ndone++;
            end
        end
    end

    task automatic run_conv(input logic sar, input int lvl, input bit stray);
        exp_t e;
        e.sar = sar;
        e.over = 1'b0;
        if (!sar) begin
            if (lvl > MAXV) begin e.res = W'(MAXV); e.over = 1'b1; e.lat = (MAXV + 1) * STEP; end
            else            begin e.res = W'(lvl);  e.lat = (lvl + 1) * STEP; end
        end else begin
            e.res = (lvl == 0) ? '0 : W'(lvl - 1);
            e.lat = W * STEP;
        end
        vin = (W + 1)'(lvl);
        @(negedge clk);
        start = 1'b1;
        mode  = sar;
        @(negedge clk);
        start = 1'b0;
        e.t0 = cyc;
        q.push_back(e);
        issued++;
        check("R8 result stable across start", int'(result), int'(last_res));
        if (sar) check("R5 first sar trial", int'(code), 1 << (W - 1));
        else     check("R2 first ramp trial", int'(code), 0);
        repeat (STEP) @(negedge clk);
        if (sar)
            check("R6 second sar trial", int'(code),
                  (lvl > (1 << (W - 1))) ? (3 << (W - 2)) : (1 << (W - 2)));
        else if (lvl > 0)
            check("R2 ramp increment", int'(code), 1);
        if (stray) begin
            repeat (2) @(negedge clk);
            start = 1'b1;
            mode  = ~sar;
            @(negedge clk);
            start = 1'b0;
            mode  = sar;
        end
        while (ndone != issued) @(negedge clk);
        last_res = e.res;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset code", int'(code), 0);
        check("R1 reset result", int'(result), 0);
        check("R1 reset over", int'(over), 0);
        check("R1 reset done", int'(done), 0);

        run_conv(1'b0, 0, 1'b0);           // R3 immediate stop
        run_conv(1'b0, 37, 1'b0);          // R3 mid-scale ramp
        run_conv(1'b0, 1, 1'b0);
        run_conv(1'b0, MAXV + 1, 1'b0);    // R4 overrange
        run_conv(1'b1, MAXV + 1, 1'b0);    // R6 clears over flag
        run_conv(1'b1, 0, 1'b0);
        run_conv(1'b1, 1, 1'b0);
        run_conv(1'b1, 513, 1'b0);
        run_conv(1'b1, 682, 1'b0);
        run_conv(1'b0, MAXV, 1'b0);        // R3 full scale without overrange
        run_conv(1'b1, 300, 1'b1);         // R9 stray start mid-conversion
        run_conv(1'b0, 5, 1'b1);           // R9 stray start during ramp

        repeat (20) @(negedge clk);
        check("R9 done count", ndone, issued);
        check("R9 queue drained", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d conversions", ndone, issued);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule